// File: doc/BRIEF.md
# Reconfigurable 8-bit Multiplier Tree

This block multiplies one pair of 8-bit operands in one of three precisions, chosen on every input beat by a 2-bit precision select. It can form a single signed 8x8 product, two independent signed 4x4 products or four independent signed 2x2 products. The result is always packed into the same 16-bit output word. The whole tree is built from 2x2 leaf multipliers. Four leaves with shifts and adds make a 4-bit sub-tree. Four sub-trees feeding a combining adder make the full 8-bit tree.

The leaves are reused across precisions. In the wide mode, every leaf takes part, and the low operand slices are treated as unsigned magnitudes so that the shifted sum is exact for two's-complement inputs. In the packed modes, only the two diagonal sub-trees are used. In the 2-bit mode, only the diagonal leaves of those sub-trees are used. The cross-term sub-trees have their operands forced to zero. Because of this, the output width stays at 16 bits in every mode. An optional output register with a valid bit gives a fixed latency of one cycle. This register is enabled by default.

Top module: `prec_mul8_tree`

## Requirements
- R1: With select 00, `res_o` is the 16-bit two's-complement product of `opa_i` and `opb_i`, both taken as signed 8-bit values.
- R2: With select 01, `res_o[7:0]` is the signed product of `opa_i[3:0]` and `opb_i[3:0]`, and `res_o[15:8]` is the signed product of `opa_i[7:4]` and `opb_i[7:4]`. Each lane is an 8-bit two's-complement value.
- R3: With select 10, for each lane k from 0 to 3, `res_o[4k+3:4k]` is the signed product of `opa_i[2k+1:2k]` and `opb_i[2k+1:2k]`, as a 4-bit two's-complement value. This includes -2 times -2, which gives 4.
- R4: Select 11 is reserved, and an accepted beat with that select gives `res_o` equal to zero.
- R5: With the output register enabled, `vld_o` and the result of a beat appear one clock after the beat is presented with `vld_i` high.
- R6: A cycle with `vld_i` low leaves `res_o` unchanged and drives `vld_o` low on the following clock, whatever the operands and select are in that cycle.
- R7: While `rst_n` is low, `vld_o` and `res_o` are zero, even if `vld_i` is high.
- R8: The precision can change on every beat, and back-to-back beats in different modes each give their own mode's result with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Input beat valid |
| prec_i | input | 2 | Precision select: 00 8-bit, 01 4-bit, 10 2-bit, 11 reserved |
| opa_i | input | 8 | Operand A, with lanes packed from the LSB |
| opb_i | input | 8 | Operand B, with lanes packed from the LSB |
| vld_o | output | 1 | Result valid |
| res_o | output | 16 | Product or packed lane products |

## Verification
The bench targets the most negative operands in every mode: -128 squared, -8 squared in each 4-bit lane, and -2 squared in each 2-bit lane. A tree that got the sign handling of the low slices or the leaves wrong would give a wrong sign or a bad magnitude exactly there. It also checks that no carry crosses between packed lanes, for example with mixed-sign lanes. A design that still summed the cross terms in packed modes would corrupt the upper lanes. Random beats switch precision on every cycle, mixed with idle cycles and reserved selects. These expose a stale output mux, a result register that loads while idle, and a reserved code that leaks a product.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   typedef enum logic [1:0] {
      PREC_W8  = 2'b00,
      PREC_W4  = 2'b01,
      PREC_W2  = 2'b10,
      PREC_RSV = 2'b11
   } prec_e;

endpackage

// File: rtl/pmt_leaf_mul.sv
// Smallest multiplier of the tree: one LW x LW product. Each operand is
// taken as signed or unsigned depending on its own flag.
module pmt_leaf_mul #(
   parameter int LW = 2
) (
   input  logic [LW-1:0]           a,
   input  logic [LW-1:0]           b,
   input  logic                    a_sgn,
   input  logic                    b_sgn,
   output logic signed [2*LW+1:0]  p
);
   localparam int PW = 2*LW + 2;

   logic signed [LW:0] ax;
   logic signed [LW:0] bx;

   // One extra bit: a sign copy for signed slices, zero for unsigned ones
   assign ax = {a_sgn & a[LW-1], a};
   assign bx = {b_sgn & b[LW-1], b};

   assign p = PW'(ax) * PW'(bx);

endmodule

// File: rtl/pmt_sub_tree.sv
// Mid-level sub-tree: four leaves. Either one SW x SW product (shift-add
// of the four leaf products) or, when split, two independent leaf lanes.
module pmt_sub_tree #(
   parameter int LW = 2
) (
   input  logic [2*LW-1:0]          a,
   input  logic [2*LW-1:0]          b,
   input  logic                     a_sgn,
   input  logic                     b_sgn,
   input  logic                     split,
   output logic signed [4*LW+1:0]   res
);
   localparam int SW   = 2*LW;
   localparam int LPW  = 2*LW + 2;
   localparam int RW   = 2*SW + 2;
   localparam int LANE = 2*LW;

   logic signed [LPW-1:0] lp [2][2];
   logic signed [RW-1:0]  full;

   for (genvar gi = 0; gi < 2; gi++) begin : g_ai
      for (genvar gj = 0; gj < 2; gj++) begin : g_bj
         localparam bit CROSS = (gi != gj);
         logic [LW-1:0] sa;
         logic [LW-1:0] sb;
         logic          sga;
         logic          sgb;

         // Cross leaves are idle in split mode: operands forced to zero
         assign sa = (CROSS && split) ? '0 : a[gi*LW +: LW];
         assign sb = (CROSS && split) ? '0 : b[gj*LW +: LW];

         // The upper slice carries the operand sign. Lower slices are unsigned
         // magnitudes, except when split, where every lane is signed.
         if (gi == 1) begin : g_sa_hi
            assign sga = a_sgn | split;
         end else begin : g_sa_lo
            assign sga = split;
         end
         if (gj == 1) begin : g_sb_hi
            assign sgb = b_sgn | split;
         end else begin : g_sb_lo
            assign sgb = split;
         end

         pmt_leaf_mul #(.LW(LW)) leaf_i (
            .a     (sa),
            .b     (sb),
            .a_sgn (sga),
            .b_sgn (sgb),
            .p     (lp[gi][gj])
         );
      end
   end

   assign full = (RW'(lp[1][1]) <<< (2*LW))
               + ((RW'(lp[1][0]) + RW'(lp[0][1])) <<< LW)
               + RW'(lp[0][0]);

   assign res = split ? RW'({lp[1][1][LANE-1:0], lp[0][0][LANE-1:0]}) : full;

endmodule

// File: rtl/pmt_out_stage.sv
// Output stage: either a result register with a valid bit, or a pass-through.
module pmt_out_stage #(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_in,
   input  logic [W-1:0] d,
   output logic         vld_out,
   output logic [W-1:0] q
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_out <= 1'b0;
            q       <= '0;
         end else begin
            vld_out <= vld_in;
            if (vld_in) begin
               q <= d;
            end
         end
      end
   end else begin : g_comb
      assign vld_out = vld_in;
      assign q       = d;
   end

endmodule

// File: rtl/prec_mul8_tree.sv
module prec_mul8_tree #(
   parameter int OP_W    = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [1:0]        prec_i,
   input  logic [OP_W-1:0]   opa_i,
   input  logic [OP_W-1:0]   opb_i,
   output logic              vld_o,
   output logic [2*OP_W-1:0] res_o
);
   import pmt_pkg::*;

   localparam int SUB_W = OP_W / 2;
   localparam int LW    = OP_W / 4;
   localparam int LANE  = 2*LW;
   localparam int SPW   = 2*SUB_W + 2;
   localparam int PW    = 2*OP_W;

   if ((OP_W < 4) || (OP_W % 4 != 0)) begin : g_bad_width
      $error("prec_mul8_tree: OP_W must be a multiple of 4, at least 4");
   end

   prec_e sel;
   logic  mode_w8;
   logic  packed_m;
   logic  split_m;

   assign sel      = prec_e'(prec_i);
   assign mode_w8  = (sel == PREC_W8);
   assign packed_m = (sel == PREC_W4) || (sel == PREC_W2);
   assign split_m  = (sel == PREC_W2);

   logic signed [SPW-1:0] sub_res [2][2];

   for (genvar gi = 0; gi < 2; gi++) begin : g_sa
      for (genvar gj = 0; gj < 2; gj++) begin : g_sb
         localparam bit CROSS = (gi != gj);
         logic [SUB_W-1:0] sa;
         logic [SUB_W-1:0] sb;
         logic             sga;
         logic             sgb;

         // Cross sub-trees only contribute in the wide mode
         assign sa = (CROSS && !mode_w8) ? '0 : opa_i[gi*SUB_W +: SUB_W];
         assign sb = (CROSS && !mode_w8) ? '0 : opb_i[gj*SUB_W +: SUB_W];

         if (gi == 1) begin : g_sa_hi
            assign sga = 1'b1;
         end else begin : g_sa_lo
            assign sga = packed_m;
         end
         if (gj == 1) begin : g_sb_hi
            assign sgb = 1'b1;
         end else begin : g_sb_lo
            assign sgb = packed_m;
         end

         pmt_sub_tree #(.LW(LW)) sub_i (
            .a     (sa),
            .b     (sb),
            .a_sgn (sga),
            .b_sgn (sgb),
            .split (split_m & ~CROSS),
            .res   (sub_res[gi][gj])
         );
      end
   end

   // Combining adder. It works modulo 2^PW, which is exact for the wide product.
   logic signed [PW-1:0] comb;
   assign comb = (PW'(sub_res[1][1]) <<< (2*SUB_W))
               + ((PW'(sub_res[1][0]) + PW'(sub_res[0][1])) <<< SUB_W)
               + PW'(sub_res[0][0]);

   logic [PW-1:0] nxt;
   always_comb begin
      case (sel)
         PREC_W8: nxt = comb;
         PREC_W4: nxt = {sub_res[1][1][2*SUB_W-1:0], sub_res[0][0][2*SUB_W-1:0]};
         PREC_W2: nxt = {sub_res[1][1][2*LANE-1:0], sub_res[0][0][2*LANE-1:0]};
         default: nxt = '0;
      endcase
   end

   pmt_out_stage #(.W(PW), .REG_OUT(REG_OUT)) out_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (vld_i),
      .d       (nxt),
      .vld_out (vld_o),
      .q       (res_o)
   );

endmodule

// File: rtl/pmt_chk.sv
module pmt_chk #(
   parameter int OP_W    = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vld_i,
   input logic [1:0]        prec_i,
   input logic [OP_W-1:0]   opa_i,
   input logic [OP_W-1:0]   opb_i,
   input logic              vld_o,
   input logic [2*OP_W-1:0] res_o
);
   localparam int PW   = 2*OP_W;
   localparam int SUB_W = OP_W / 2;
   localparam int LANE = OP_W / 2;

   logic signed [PW-1:0]     ref_w8;
   logic signed [OP_W-1:0]   ref_w4lo;
   logic signed [LANE-1:0]   ref_w2l0;

   assign ref_w8   = PW'($signed(opa_i)) * PW'($signed(opb_i));
   assign ref_w4lo = OP_W'($signed(opa_i[SUB_W-1:0])) * OP_W'($signed(opb_i[SUB_W-1:0]));
   assign ref_w2l0 = LANE'($signed(opa_i[OP_W/4-1:0])) * LANE'($signed(opb_i[OP_W/4-1:0]));

   if (REG_OUT) begin : g_seq
      AST_W8_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b00 |=> res_o == $past(ref_w8)); // R1
      AST_W4_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b01 |=> res_o[OP_W-1:0] == $past(ref_w4lo)); // R2
      AST_W2_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b10 |=> res_o[LANE-1:0] == $past(ref_w2l0)); // R3
      AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b11 |=> res_o == '0); // R4
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i |=> vld_o); // R5
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !vld_i |=> $stable(res_o) && !vld_o); // R6
   end else begin : g_comb
      AST_W8_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b00 |-> res_o == ref_w8); // R1
      AST_W4_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b01 |-> res_o[OP_W-1:0] == ref_w4lo); // R2
      AST_W2_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b10 |-> res_o[LANE-1:0] == ref_w2l0); // R3
      AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i && prec_i == 2'b11 |-> res_o == '0); // R4
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         vld_o == vld_i); // R5
   end

endmodule

bind prec_mul8_tree pmt_chk #(.OP_W(OP_W), .REG_OUT(REG_OUT)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .vld_i  (vld_i),
   .prec_i (prec_i),
   .opa_i  (opa_i),
   .opb_i  (opb_i),
   .vld_o  (vld_o),
   .res_o  (res_o)
);

// File: tb/prec_mul8_tree_tb.sv
`timescale 1ns/1ps
module prec_mul8_tree_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_i = 1'b0;
   logic [1:0]  prec_i = 2'b00;
   logic [7:0]  opa_i = 8'h00;
   logic [7:0]  opb_i = 8'h00;
   logic        vld_o;
   logic [15:0] res_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // Expected state of the previous beat
   bit          prev_v = 1'b0;
   bit          have_prev = 1'b0;
   logic [15:0] prev_exp = 16'h0;
   logic [15:0] held = 16'h0;
   string       prev_tag = "";
   logic [1:0]  last_mode = 2'b00;
   bit          last_was_valid = 1'b0;

   always #2.5 clk = ~clk;

   prec_mul8_tree dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (vld_i),
      .prec_i (prec_i),
      .opa_i  (opa_i),
      .opb_i  (opb_i),
      .vld_o  (vld_o),
      .res_o  (res_o)
   );

   function automatic int sx(int v, int w);
      return (v >= (1 << (w-1))) ? v - (1 << w) : v;
   endfunction

   function automatic logic [15:0] model(logic [1:0] p, logic [7:0] x, logic [7:0] y);
      logic [15:0] o;
      int r;
      o = 16'h0;
      case (p)
         2'b00: begin
            r = sx(int'(x), 8) * sx(int'(y), 8);
            o = r[15:0];
         end
         2'b01: begin
            for (int k = 0; k < 2; k++) begin
               r = sx(int'(x[4*k +: 4]), 4) * sx(int'(y[4*k +: 4]), 4);
               o[8*k +: 8] = r[7:0];
            end
         end
         2'b10: begin
            for (int k = 0; k < 4; k++) begin
               r = sx(int'(x[2*k +: 2]), 2) * sx(int'(y[2*k +: 2]), 2);
               o[4*k +: 4] = r[3:0];
            end
         end
         default: o = 16'h0;
      endcase
      return o;
   endfunction

   function automatic string mode_tag(logic [1:0] p);
      case (p)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock: check the previous beat's outputs, then drive the next beat
   task automatic step(bit v, logic [1:0] p, logic [7:0] x, logic [7:0] y);
      string tag;
      @(negedge clk);
      if (have_prev) begin
         if (prev_v) begin
            chk({"R5 vld_o after ", prev_tag}, {15'h0, vld_o}, 16'h1);
            chk(prev_tag, res_o, prev_exp);
            held = prev_exp;
         end else begin
            chk("R6 vld_o low after idle", {15'h0, vld_o}, 16'h0);
            chk("R6 res_o held after idle", res_o, held);
         end
      end
      tag = mode_tag(p);
      // R8: back-to-back beats with a mode change
      if (v && last_was_valid && prev_v && (p != last_mode))
         tag = {"R8 ", tag};
      vld_i  = v;
      prec_i = p;
      opa_i  = x;
      opb_i  = y;
      have_prev = 1'b1;
      prev_v    = v;
      prev_tag  = tag;
      prev_exp  = model(p, x, y);
      if (v) begin
         last_mode = p;
      end
      last_was_valid = v;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      // R7: outputs stay cleared under reset even with a live beat
      vld_i  = 1'b1;
      prec_i = 2'b00;
      opa_i  = 8'h7f;
      opb_i  = 8'h7f;
      repeat (3) @(negedge clk);
      chk("R7 vld_o in reset", {15'h0, vld_o}, 16'h0);
      chk("R7 res_o in reset", res_o, 16'h0);
      vld_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // Directed corner cases
      step(1, 2'b00, 8'h80, 8'h80);   // R1: -128*-128 = 0x4000
      step(1, 2'b00, 8'h80, 8'h7f);   // R1
      step(1, 2'b00, 8'h7f, 8'h7f);   // R1
      step(1, 2'b00, 8'hff, 8'hff);   // R1: -1*-1
      step(1, 2'b00, 8'h0f, 8'hf0);   // R1: mixed nibbles
      step(1, 2'b01, 8'h88, 8'h88);   // R2: -8*-8 in both lanes
      step(1, 2'b01, 8'h87, 8'h78);   // R2: mixed-sign lanes
      step(1, 2'b01, 8'hf1, 8'h1f);   // R2
      step(1, 2'b10, 8'haa, 8'haa);   // R3: -2*-2 in all lanes
      step(1, 2'b10, 8'h1b, 8'he4);   // R3
      step(1, 2'b11, 8'h7f, 8'h7f);   // R4: reserved gives zero
      step(0, 2'b00, 8'h12, 8'h34);   // R6: idle beat is ignored
      step(0, 2'b11, 8'hff, 8'h80);   // R6
      step(1, 2'b10, 8'h55, 8'hff);   // R3
      step(1, 2'b00, 8'h80, 8'h01);   // R8: mode switch

      // Constrained random, with mode switching and idle gaps
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] p;
         bit v;
         p = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
         v = ($urandom_range(0, 7) != 0);
         step(v, p, 8'($urandom()), 8'($urandom()));
      end
      step(0, 2'b00, 8'h00, 8'h00);
      step(0, 2'b00, 8'h00, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R5 watchdog expired: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

endmodule